// File: doc/BRIEF.md
# GPIO Port with Peripheral Pin Override

An eight-pin general-purpose I/O port. Software sets each pin's direction and output level through a direction register and an output register. The output register bit also requests the pull-up on a pin that is an input. Every pad value passes through a two-stage synchronizer before it reaches the read bus and the on-chip peripherals.

Four peripherals can take over pins through per-pin override-enable and override-value pairs for pull-up, direction and output. A serial transmitter forces its data pin to output. A serial receiver forces its pin to input but leaves the pull-up under software control. The serial clock pin becomes an output when the serial unit asks for it. A two-wire bus forces its two pins to open-drain drive. The timer and capture pins, and the external-interrupt inputs on the low nibble, only read the synchronized pad value.

Pin assignment, which the override mapping depends on:

| Bit | Function |
|-----|----------|
| 0 | two-wire clock |
| 1 | two-wire data |
| 2 | serial receive |
| 3 | serial transmit |
| 4 | capture input |
| 5 | serial clock |
| 6 | timer-1 input |
| 7 | timer-0 input |

Bits 0 to 3 also feed the external-interrupt logic.

Top module: `gpio_altfn_port`

## Requirements
- R1: While `rst` is high, the direction register, the output register and the synchronizer all clear to zero. With no override active, all pads are then released: `pad_oe`, `pad_out` and `pad_pu` are 0.
- R2: A write with `wr_en` loads `wr_data` at the clock edge. Address 0 is the direction register and address 1 is the output register. Writes to address 2 or 3 change nothing. The read bus is combinational: `rd_addr` 0 returns the direction register, 1 returns the output register, 2 returns the synchronized pins and 3 returns zero.
- R3: On a pin with no override, `pad_oe` equals its direction bit and `pad_out` equals its output register bit.
- R4: On a pin with no pull-up override, `pad_pu` is 1 only when the pin's final direction is input, its output register bit is 1 and `pull_dis` is 0. A pin never has `pad_pu` and `pad_oe` both at 1.
- R5: While `uart_tx_en` is 1, bit 3 drives (`pad_oe[3]`=1) with `pad_out[3]` = `uart_tx_data`, whatever its direction bit holds.
- R6: While `uart_rx_en` is 1, bit 2 is an input (`pad_oe[2]`=0) whatever its direction bit holds. Its `pad_pu` still follows its output register bit and `pull_dis`.
- R7: While `twi_en` is 1, bits 0 and 1 are open-drain. `pad_out` is 0 and `pad_pu` is 0 on both. `pad_oe[0]` is the inverse of `twi_scl_out` and `pad_oe[1]` is the inverse of `twi_sda_out`.
- R8: While `uart_xck_oe` is 1, bit 5 drives `uart_xck_out`. While `uart_xck_oe` is 0, bit 5 follows its registers.
- R9: Bits 4, 6 and 7 are never overridden. They behave as in R3 and R4 in every peripheral mode.
- R10: A change on `pad_in` appears on `pin_sync` and on the read bus at address 2 exactly two clock edges later. This holds for every pin whatever its direction, so the interrupt inputs on bits 0 to 3 see driven pins too.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 2 | write address (0 direction, 1 output) |
| wr_data | input | 8 | write data |
| rd_addr | input | 2 | read address |
| rd_data | output | 8 | read data |
| pull_dis | input | 1 | global pull-up disable |
| twi_en | input | 1 | two-wire bus owns bits 0 and 1 |
| twi_sda_out | input | 1 | two-wire data level to drive |
| twi_scl_out | input | 1 | two-wire clock level to drive |
| uart_rx_en | input | 1 | serial receiver enabled |
| uart_tx_en | input | 1 | serial transmitter enabled |
| uart_tx_data | input | 1 | serial transmit bit |
| uart_xck_oe | input | 1 | serial clock output enable |
| uart_xck_out | input | 1 | serial clock output level |
| pad_in | input | 8 | raw pad levels |
| pad_oe | output | 8 | pad output enable |
| pad_out | output | 8 | pad output data |
| pad_pu | output | 8 | pad pull-up enable |
| pin_sync | output | 8 | synchronized pad levels to peripherals |

## Verification
The bench builds the port with its default two synchronizer stages and eight pins. Under that build, the one-edge and two-edge points of the pin-read latency fall on fixed cycles the bench can sample. The full fixed pin map, including the open-drain pair, the forced-input receive pin and the three unmapped upper pins, is also in reach in a single instance.

// File: rtl/gpio_altfn_pkg.sv
package gpio_altfn_pkg;

    localparam int PORT_W = 8;

    // pin positions; the override mapping depends on them
    localparam int PIN_SCL = 0;
    localparam int PIN_SDA = 1;
    localparam int PIN_RXD = 2;
    localparam int PIN_TXD = 3;
    localparam int PIN_ICP = 4;
    localparam int PIN_XCK = 5;
    localparam int PIN_T1  = 6;
    localparam int PIN_T0  = 7;

    typedef enum logic [1:0] {
        REG_DIR  = 2'd0,
        REG_OUT  = 2'd1,
        REG_PIN  = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic pu_en;
        logic pu_val;
        logic dir_en;
        logic dir_val;
        logic out_en;
        logic out_val;
    } pin_ovr_t;

    typedef struct packed {
        logic oe;
        logic dout;
        logic pu;
    } pad_ctl_t;

    function automatic pad_ctl_t resolve_pin(pin_ovr_t o, logic dir_r,
                                             logic out_r, logic pud);
        pad_ctl_t c;
        c.oe   = o.dir_en ? o.dir_val : dir_r;
        c.dout = o.out_en ? o.out_val : out_r;
        c.pu   = o.pu_en  ? o.pu_val  : (!c.oe && out_r && !pud);
        return c;
    endfunction

endpackage

// File: rtl/gpio_sync_chain.sv
module gpio_sync_chain #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d_in;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign d_out = stg[STAGES-1];

    // cycles since reset, saturating; gates the latency check
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst) age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    generate
        if (STAGES == 2) begin : g_lat_chk
            assert_sync_latency_R10: assert property (@(posedge clk) disable iff (rst)
                (age_q >= 2'd2) |-> (d_out == $past(d_in, 2)));
        end
    endgenerate

endmodule

// File: rtl/gpio_ovr_map.sv
module gpio_ovr_map
    import gpio_altfn_pkg::*;
(
    input  logic twi_en,
    input  logic twi_sda_out,
    input  logic twi_scl_out,
    input  logic uart_rx_en,
    input  logic uart_tx_en,
    input  logic uart_tx_data,
    input  logic uart_xck_oe,
    input  logic uart_xck_out,
    output pin_ovr_t [PORT_W-1:0] ovr
);
    always_comb begin
        ovr = '0;
        // two-wire bus: drive low for 0, release for 1, no pull-up
        ovr[PIN_SCL] = '{pu_en: twi_en, pu_val: 1'b0,
                         dir_en: twi_en, dir_val: !twi_scl_out,
                         out_en: twi_en, out_val: 1'b0};
        ovr[PIN_SDA] = '{pu_en: twi_en, pu_val: 1'b0,
                         dir_en: twi_en, dir_val: !twi_sda_out,
                         out_en: twi_en, out_val: 1'b0};
        // receive: direction forced to input, pull-up left to software
        ovr[PIN_RXD].dir_en  = uart_rx_en;
        ovr[PIN_RXD].dir_val = 1'b0;
        // transmit: forced output carrying serial data
        ovr[PIN_TXD].dir_en  = uart_tx_en;
        ovr[PIN_TXD].dir_val = 1'b1;
        ovr[PIN_TXD].out_en  = uart_tx_en;
        ovr[PIN_TXD].out_val = uart_tx_data;
        // serial clock: output when the serial unit enables it
        ovr[PIN_XCK].dir_en  = uart_xck_oe;
        ovr[PIN_XCK].dir_val = 1'b1;
        ovr[PIN_XCK].out_en  = uart_xck_oe;
        ovr[PIN_XCK].out_val = uart_xck_out;
        // PIN_ICP, PIN_T1, PIN_T0 stay free of overrides
    end
endmodule

// File: rtl/gpio_pin_resolve.sv
module gpio_pin_resolve
    import gpio_altfn_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  pin_ovr_t [PORT_W-1:0] ovr,
    input  logic [PORT_W-1:0]     dir_q,
    input  logic [PORT_W-1:0]     out_q,
    input  logic                  pull_dis,
    output logic [PORT_W-1:0]     pad_oe,
    output logic [PORT_W-1:0]     pad_out,
    output logic [PORT_W-1:0]     pad_pu
);
    generate
        for (genvar p = 0; p < PORT_W; p++) begin : g_pin
            pad_ctl_t ctl;
            assign ctl        = resolve_pin(ovr[p], dir_q[p], out_q[p], pull_dis);
            assign pad_oe[p]  = ctl.oe;
            assign pad_out[p] = ctl.dout;
            assign pad_pu[p]  = ctl.pu;

            assert_no_pu_on_output_R4: assert property (@(posedge clk) disable iff (rst)
                !(pad_pu[p] && pad_oe[p]));
        end
    endgenerate
endmodule

// File: rtl/gpio_altfn_port.sv
module gpio_altfn_port
    import gpio_altfn_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [PORT_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [PORT_W-1:0] rd_data,
    input  logic              pull_dis,
    input  logic              twi_en,
    input  logic              twi_sda_out,
    input  logic              twi_scl_out,
    input  logic              uart_rx_en,
    input  logic              uart_tx_en,
    input  logic              uart_tx_data,
    input  logic              uart_xck_oe,
    input  logic              uart_xck_out,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_pu,
    output logic [PORT_W-1:0] pin_sync
);
    logic [PORT_W-1:0]     dir_q, out_q;
    pin_ovr_t [PORT_W-1:0] ovr;
    reg_sel_e              wsel, rsel;

    assign wsel = reg_sel_e'(wr_addr);
    assign rsel = reg_sel_e'(rd_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '0;
            out_q <= '0;
        end else if (wr_en) begin
            if (wsel == REG_DIR) dir_q <= wr_data;
            if (wsel == REG_OUT) out_q <= wr_data;
        end
    end

    always_comb begin
        case (rsel)
            REG_DIR: rd_data = dir_q;
            REG_OUT: rd_data = out_q;
            REG_PIN: rd_data = pin_sync;
            default: rd_data = '0;
        endcase
    end

    gpio_sync_chain #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_in(pad_in), .d_out(pin_sync)
    );

    gpio_ovr_map u_map (
        .twi_en(twi_en), .twi_sda_out(twi_sda_out), .twi_scl_out(twi_scl_out),
        .uart_rx_en(uart_rx_en), .uart_tx_en(uart_tx_en),
        .uart_tx_data(uart_tx_data), .uart_xck_oe(uart_xck_oe),
        .uart_xck_out(uart_xck_out), .ovr(ovr)
    );

    gpio_pin_resolve u_res (
        .clk(clk), .rst(rst), .ovr(ovr), .dir_q(dir_q), .out_q(out_q),
        .pull_dis(pull_dis), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    assert_dir_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd0) |=> (dir_q == $past(wr_data)));

    assert_tx_forced_R5: assert property (@(posedge clk) disable iff (rst)
        uart_tx_en |-> (pad_oe[PIN_TXD] && pad_out[PIN_TXD] == uart_tx_data));

    assert_rx_forced_R6: assert property (@(posedge clk) disable iff (rst)
        uart_rx_en |-> (!pad_oe[PIN_RXD] &&
                        pad_pu[PIN_RXD] == (out_q[PIN_RXD] && !pull_dis)));

    assert_twi_open_drain_R7: assert property (@(posedge clk) disable iff (rst)
        twi_en |-> (!pad_out[PIN_SCL] && !pad_out[PIN_SDA] &&
                    pad_oe[PIN_SCL] == !twi_scl_out &&
                    pad_oe[PIN_SDA] == !twi_sda_out));

    assert_upper_free_R9: assert property (@(posedge clk) disable iff (rst)
        (pad_oe[PIN_ICP] == dir_q[PIN_ICP]) && (pad_oe[PIN_T1] == dir_q[PIN_T1]) &&
        (pad_oe[PIN_T0] == dir_q[PIN_T0]));

endmodule

// File: tb/gpio_altfn_port_tb.sv
module gpio_altfn_port_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       pull_dis = 1'b0;
    logic       twi_en = 1'b0, twi_sda_out = 1'b0, twi_scl_out = 1'b0;
    logic       uart_rx_en = 1'b0, uart_tx_en = 1'b0, uart_tx_data = 1'b0;
    logic       uart_xck_oe = 1'b0, uart_xck_out = 1'b0;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_oe, pad_out, pad_pu, pin_sync;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    gpio_altfn_port u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pull_dis(pull_dis),
        .twi_en(twi_en), .twi_sda_out(twi_sda_out), .twi_scl_out(twi_scl_out),
        .uart_rx_en(uart_rx_en), .uart_tx_en(uart_tx_en), .uart_tx_data(uart_tx_data),
        .uart_xck_oe(uart_xck_oe), .uart_xck_out(uart_xck_out), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pin_sync(pin_sync)
    );

    typedef struct packed {
        logic [7:0] ddr, port;
        logic pud, twi, sda, scl, rxe, txe, txd, xoe, xo;
        logic [7:0] e_oe, e_out, e_pu;
    } vec_t;

    // ddr port pud twi sda scl rxe txe txd xoe xo | oe out pu
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 8'h00, 1'b0, 1'b0,1'b0,1'b0, 1'b0, 1'b0,1'b0, 1'b0,1'b0, 8'h00, 8'h00, 8'h00}, // R3 R4
        '{8'hF0, 8'hFF, 1'b0, 1'b0,1'b0,1'b0, 1'b0, 1'b0,1'b0, 1'b0,1'b0, 8'hF0, 8'hFF, 8'h0F}, // R3 R4 R9
        '{8'hF0, 8'hFF, 1'b1, 1'b0,1'b0,1'b0, 1'b0, 1'b0,1'b0, 1'b0,1'b0, 8'hF0, 8'hFF, 8'h00}, // R4 pull_dis
        '{8'h00, 8'hAA, 1'b0, 1'b0,1'b0,1'b0, 1'b0, 1'b1,1'b0, 1'b0,1'b0, 8'h08, 8'hA2, 8'hA2}, // R5
        '{8'hFF, 8'h04, 1'b0, 1'b0,1'b0,1'b0, 1'b1, 1'b0,1'b0, 1'b0,1'b0, 8'hFB, 8'h04, 8'h04}, // R6
        '{8'h00, 8'hFF, 1'b0, 1'b1,1'b0,1'b1, 1'b0, 1'b0,1'b0, 1'b0,1'b0, 8'h02, 8'hFC, 8'hFC}, // R7
        '{8'h03, 8'h03, 1'b0, 1'b1,1'b1,1'b0, 1'b0, 1'b0,1'b0, 1'b0,1'b0, 8'h01, 8'h00, 8'h00}, // R7
        '{8'h00, 8'h00, 1'b0, 1'b0,1'b0,1'b0, 1'b0, 1'b0,1'b0, 1'b1,1'b1, 8'h20, 8'h20, 8'h00}, // R8
        '{8'h20, 8'h00, 1'b0, 1'b0,1'b0,1'b0, 1'b0, 1'b0,1'b0, 1'b0,1'b1, 8'h20, 8'h00, 8'h00}, // R8
        '{8'h04, 8'h0C, 1'b0, 1'b0,1'b0,1'b0, 1'b1, 1'b1,1'b1, 1'b0,1'b0, 8'h08, 8'h0C, 8'h04}  // R5 R6
    };

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(logic [1:0] a, string req, logic [7:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic periph_idle();
        pull_dis = 0; twi_en = 0; twi_sda_out = 0; twi_scl_out = 0;
        uart_rx_en = 0; uart_tx_en = 0; uart_tx_data = 0;
        uart_xck_oe = 0; uart_xck_out = 0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        reg_read(2'd0, "R1 dir", 8'h00);
        reg_read(2'd1, "R1 out", 8'h00);
        check("R1 oe", pad_oe, 8'h00);
        check("R1 pu", pad_pu, 8'h00);
        rst = 1'b0;

        // table walk: R3..R9
        for (int i = 0; i < NV; i++) begin
            vec_t v = VECS[i];
            periph_idle();
            reg_write(2'd0, v.ddr);
            reg_write(2'd1, v.port);
            pull_dis = v.pud; twi_en = v.twi; twi_sda_out = v.sda; twi_scl_out = v.scl;
            uart_rx_en = v.rxe; uart_tx_en = v.txe; uart_tx_data = v.txd;
            uart_xck_oe = v.xoe; uart_xck_out = v.xo;
            #1;
            check($sformatf("R3-vec%0d oe", i), pad_oe, v.e_oe);
            check($sformatf("R3-vec%0d out", i), pad_out, v.e_out);
            check($sformatf("R4-vec%0d pu", i), pad_pu, v.e_pu);
        end
        periph_idle();

        // R2: readback and ignored addresses
        reg_write(2'd0, 8'h5C);
        reg_write(2'd1, 8'hA3);
        reg_read(2'd0, "R2 dir", 8'h5C);
        reg_read(2'd1, "R2 out", 8'hA3);
        reg_write(2'd3, 8'hFF);
        reg_write(2'd2, 8'h11);
        reg_read(2'd0, "R2 dir after ignored writes", 8'h5C);
        reg_read(2'd1, "R2 out after ignored writes", 8'hA3);
        reg_read(2'd3, "R2 addr3 reads zero", 8'h00);

        // R10: two-edge latency
        reg_read(2'd2, "R10 pins before", 8'h00);
        @(negedge clk);
        pad_in = 8'h5A;
        @(negedge clk);
        check("R10 one edge", pin_sync, 8'h00);
        @(negedge clk);
        check("R10 two edges", pin_sync, 8'h5A);
        reg_read(2'd2, "R10 read bus", 8'h5A);

        // R10: driven low pins still reach the interrupt inputs
        reg_write(2'd0, 8'h0F);
        pad_in = 8'h03;
        repeat (2) @(negedge clk);
        check("R10 int pins while driven", {4'h0, pin_sync[3:0]}, 8'h03);

        // R1: mid-run reset
        reg_write(2'd1, 8'hFF);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 sync cleared", pin_sync, 8'h00);
        check("R1 oe released", pad_oe, 8'h00);
        check("R1 out released", pad_out, 8'h00);
        reg_read(2'd0, "R1 dir cleared", 8'h00);
        rst = 1'b0;

        finish_run();
    end

endmodule